// File: doc/BRIEF.md
# Multi-Format Signed Adder/Subtractor

This block adds or subtracts two WIDTH-bit signed operands that are encoded in one of three negative-number formats chosen per operation: twos complement, ones complement or sign-magnitude. A single operation-select input turns the addition into a subtraction. In twos and ones complement, subtraction inverts the second operand. In sign-magnitude, it flips the sign bit of the second operand. The adjusted operands then go through the addition rule of the selected format.

The three rules are:
- **Twos complement:** a plain binary add that drops the carry out.
- **Ones complement:** a binary add whose carry out is folded back into the least significant bit.
- **Sign-magnitude:** adds magnitudes when the signs agree, and otherwise subtracts the smaller magnitude from the larger.

Each rule has its own overflow flag.

The arithmetic is combinational. Result and overflow are captured in one output register stage with a synchronous active-low reset, so a value presented before a rising clock edge appears at the outputs after that edge. Negative zero is not normalised away, and results do not saturate.

Top module: `addsub_multi_fmt`

## Requirements
- R1: With format code 0 (twos complement) and subtract low, result = (op_a + op_b) mod 2^WIDTH; the carry out is discarded.
- R2: With format code 0 and subtract high, result = (op_a + ~op_b + 1) mod 2^WIDTH.
- R3: With format code 0 or 3, overflow is high exactly when the carry into the most significant bit differs from the carry out of it, i.e. the true signed result lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R4: With format code 1 (ones complement), the second operand is bitwise inverted when subtract is high; the sum is formed without sign, and a carry out is added back into bit 0; adding a value to its inverse yields all ones (negative zero).
- R5: With format code 1, overflow is high exactly when both adjusted operands have the same sign bit and the result sign bit differs from it.
- R6: With format code 2 (sign-magnitude: bit WIDTH-1 is the sign, 1 = negative, bits WIDTH-2..0 the magnitude) and equal adjusted signs, the magnitudes are added, the common sign is kept, and overflow is the carry out of the WIDTH-1-bit magnitude sum (the result holds the low WIDTH-1 bits).
- R7: With format code 2 and different adjusted signs, the result magnitude is the larger minus the smaller magnitude with the sign of the larger, overflow is low, and equal magnitudes give positive zero (all bits 0).
- R8: With format code 2 and subtract high, only the sign bit of op_b is inverted before the R6/R7 rules apply.
- R9: Format code 3 behaves exactly as format code 0.
- R10: Result and overflow change only at a rising clock edge, one edge after the inputs, and read zero after a clock edge with rst_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sub_en | input | 1 | 1 = op_a minus op_b, 0 = op_a plus op_b |
| fmt_sel | input | 2 | 0 twos complement, 1 ones complement, 2 sign-magnitude, 3 twos complement |
| result | output | WIDTH | Registered sum or difference in the selected format |
| overflow | output | 1 | Registered overflow flag for the selected format |

## Verification
Two effects can coincide in one operation: the carry out of the raw sum and an overflow flag. In ones complement, the end-around carry can fire in the same cycle as overflow. In sign-magnitude, the magnitude carry itself becomes the overflow. These cases are provoked by sweeping every operand pair of a 5-bit instance under every format and both operations, which covers all operand pairs near the range limits and every negative zero. Each registered output is judged against a value computed from the decoded integer values of the operands: the exact result is range-checked for overflow, and the expected bit pattern is rebuilt arithmetically.

// File: rtl/addsub_fmt_pkg.sv
// Package: shared format codes for the multi-format adder/subtractor.
// Assumes a 2-bit select; code 3 is an alias of twos complement.
package addsub_fmt_pkg;
    typedef enum logic [1:0] {
        FMT_TWOS = 2'd0,
        FMT_ONES = 2'd1,
        FMT_SMAG = 2'd2,
        FMT_ALT  = 2'd3
    } num_fmt_e;
endpackage

// File: rtl/addsub_ripple.sv
// Module: ripple carry adder built from generate/propagate bit cells.
// Assumes WIDTH >= 1; returns the sum and the carry out of the top bit.
module addsub_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out
);
    logic [WIDTH:0] chain;

    assign chain[0] = c_in;

    // One full-adder cell per bit, carry rippling upward
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            logic gen_b;
            logic prop_b;
            assign gen_b        = a_in[i] & b_in[i];
            assign prop_b       = a_in[i] ^ b_in[i];
            assign sum_out[i]   = prop_b ^ chain[i];
            assign chain[i+1]   = gen_b | (prop_b & chain[i]);
        end
    endgenerate

    assign c_out = chain[WIDTH];
endmodule

// File: rtl/addsub_operand_prep.sv
// Module: forms the effective second operand for the chosen format.
// Assumes WIDTH >= 2. Complement formats invert all bits on subtract;
// sign-magnitude inverts only the sign bit.
module addsub_operand_prep
    import addsub_fmt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_raw,
    input  logic             sub_en,
    input  num_fmt_e         fmt,
    output logic [WIDTH-1:0] b_eff
);
    localparam int MSB = WIDTH - 1;

    // Select the negation style of the current format
    always_comb begin
        b_eff = b_raw;
        if (sub_en) begin
            if (fmt == FMT_SMAG) begin
                b_eff[MSB] = ~b_raw[MSB];
            end else begin
                b_eff = ~b_raw;
            end
        end
    end
endmodule

// File: rtl/addsub_smag_unit.sv
// Module: sign-magnitude add of two already sign-adjusted operands.
// Assumes WIDTH >= 2. Equal signs add magnitudes; unequal signs subtract
// the smaller from the larger; an exact cancellation yields positive zero.
module addsub_smag_unit #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] res,
    output logic             ovf
);
    localparam int MSB  = WIDTH - 1;
    localparam int MAGW = WIDTH - 1;

    logic            sgn_a;
    logic            sgn_b;
    logic [MAGW-1:0] mag_a;
    logic [MAGW-1:0] mag_b;
    logic [MAGW-1:0] mag_sum;
    logic            mag_carry;
    logic [MAGW-1:0] mag_diff;
    logic            a_ge_b;
    logic [MAGW-1:0] mag_out;
    logic            sgn_out;

    assign sgn_a = opa[MSB];
    assign sgn_b = opb[MSB];
    assign mag_a = opa[MAGW-1:0];
    assign mag_b = opb[MAGW-1:0];

    addsub_ripple #(.WIDTH(MAGW)) u_mag_add (
        .a_in   (mag_a),
        .b_in   (mag_b),
        .c_in   (1'b0),
        .sum_out(mag_sum),
        .c_out  (mag_carry)
    );

    // Carry out of a + ~b + 1 is set when mag_a >= mag_b
    addsub_ripple #(.WIDTH(MAGW)) u_mag_sub (
        .a_in   (mag_a),
        .b_in   (~mag_b),
        .c_in   (1'b1),
        .sum_out(mag_diff),
        .c_out  (a_ge_b)
    );

    // Choose same-sign sum or different-sign difference
    always_comb begin
        if (sgn_a == sgn_b) begin
            mag_out = mag_sum;
            sgn_out = sgn_a;
            ovf     = mag_carry;
        end else begin
            mag_out = a_ge_b ? mag_diff : (~mag_diff + 1'b1);
            sgn_out = a_ge_b ? sgn_a : sgn_b;
            ovf     = 1'b0;
            if (mag_out == '0) begin
                sgn_out = 1'b0;
            end
        end
        res = {sgn_out, mag_out};
    end
endmodule

// File: rtl/addsub_multi_fmt.sv
// Module: top of the multi-format adder/subtractor.
// Assumes WIDTH >= 2. Combinational arithmetic for three encodings is
// selected by fmt_sel and captured in one output register stage that
// has a synchronous active-low reset.
module addsub_multi_fmt
    import addsub_fmt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_en,
    input  logic [1:0]       fmt_sel,
    output logic [WIDTH-1:0] result,
    output logic             overflow
);
    localparam int MSB  = WIDTH - 1;
    localparam int LOWW = WIDTH - 1;

    num_fmt_e         fmt;
    logic             twos_family;
    logic [WIDTH-1:0] b_eff;
    logic             cin_main;
    logic [LOWW-1:0]  low_sum;
    logic             c_into_msb;
    logic             prop_msb;
    logic             c_out_msb;
    logic [WIDTH-1:0] raw_sum;
    logic             ones_ovf;
    logic [WIDTH-1:0] ones_res;
    logic [WIDTH-1:0] smag_res;
    logic             smag_ovf;
    logic [WIDTH-1:0] next_res;
    logic             next_ovf;

    assign fmt         = num_fmt_e'(fmt_sel);
    assign twos_family = (fmt == FMT_TWOS) || (fmt == FMT_ALT);
    assign cin_main    = sub_en & twos_family;

    addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .b_raw (op_b),
        .sub_en(sub_en),
        .fmt   (fmt),
        .b_eff (b_eff)
    );

    // Low bits ripple; their carry out is the carry into the sign bit
    addsub_ripple #(.WIDTH(LOWW)) u_low (
        .a_in   (op_a[LOWW-1:0]),
        .b_in   (b_eff[LOWW-1:0]),
        .c_in   (cin_main),
        .sum_out(low_sum),
        .c_out  (c_into_msb)
    );

    // Sign-bit cell kept separate so both carries around it are visible
    always_comb begin
        prop_msb  = op_a[MSB] ^ b_eff[MSB];
        c_out_msb = (op_a[MSB] & b_eff[MSB]) | (prop_msb & c_into_msb);
        raw_sum   = {prop_msb ^ c_into_msb, low_sum};
    end

    // Ones complement end-around carry and sign-rule overflow
    always_comb begin
        ones_res = raw_sum + {{(WIDTH-1){1'b0}}, c_out_msb};
        ones_ovf = (op_a[MSB] == b_eff[MSB]) && (ones_res[MSB] != op_a[MSB]);
    end

    addsub_smag_unit #(.WIDTH(WIDTH)) u_smag (
        .opa(op_a),
        .opb(b_eff),
        .res(smag_res),
        .ovf(smag_ovf)
    );

    // Pick the result of the selected format
    always_comb begin
        unique case (fmt)
            FMT_ONES: begin
                next_res = ones_res;
                next_ovf = ones_ovf;
            end
            FMT_SMAG: begin
                next_res = smag_res;
                next_ovf = smag_ovf;
            end
            default: begin
                next_res = raw_sum;
                next_ovf = c_into_msb ^ c_out_msb;
            end
        endcase
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            overflow <= 1'b0;
        end else begin
            result   <= next_res;
            overflow <= next_ovf;
        end
    end
endmodule

// File: rtl/addsub_multi_fmt_chk.sv
// Module: assertion checker bound to addsub_multi_fmt.
// Assumes outputs lag inputs by one rising edge.
module addsub_multi_fmt_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             sub_en,
    input logic [1:0]       fmt_sel,
    input logic [WIDTH-1:0] result,
    input logic             overflow
);
    localparam int MSB = WIDTH - 1;

    // Mixed-sign twos complement addition cannot overflow
    assert_twos_mixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) == 2'd0 && !$past(sub_en)
         && ($past(op_a[MSB]) != $past(op_b[MSB])))
        |-> !overflow);

    // Two non-negative twos complement operands give a non-negative result unless overflow
    assert_twos_pos_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) == 2'd0 && !$past(sub_en)
         && !$past(op_a[MSB]) && !$past(op_b[MSB]))
        |-> (overflow || !result[MSB]));

    // A value plus its bitwise inverse is negative zero in ones complement
    assert_ones_negzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) == 2'd1 && !$past(sub_en)
         && $past(op_b) == ~$past(op_a))
        |-> (result == {WIDTH{1'b1}} && !overflow));

    // Ones complement operands of opposite effective sign never overflow
    assert_ones_mixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) == 2'd1
         && ($past(op_a[MSB]) != ($past(op_b[MSB]) ^ $past(sub_en))))
        |-> !overflow);

    // Sign-magnitude subtraction of a value from itself is positive zero
    assert_smag_self_sub_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) == 2'd2 && $past(sub_en)
         && $past(op_a) == $past(op_b))
        |-> (result == '0 && !overflow));

    // Sign-magnitude operands of opposite effective sign never overflow
    assert_smag_mixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fmt_sel) == 2'd2
         && ($past(op_a[MSB]) != ($past(op_b[MSB]) ^ $past(sub_en))))
        |-> !overflow);
endmodule

bind addsub_multi_fmt addsub_multi_fmt_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a    (op_a),
    .op_b    (op_b),
    .sub_en  (sub_en),
    .fmt_sel (fmt_sel),
    .result  (result),
    .overflow(overflow)
);

// File: tb/addsub_multi_fmt_test.sv
// Bench: exhaustive sweep of a 5-bit instance over all formats and operations.
module addsub_multi_fmt_test;
    localparam int W    = 5;
    localparam int MASK = (1 << W) - 1;
    localparam int HALF = 1 << (W - 1);

    logic         clk;
    logic         rst_n;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         sub_en;
    logic [1:0]   fmt_sel;
    logic [W-1:0] result;
    logic         overflow;

    int n_checks;
    int n_fail;
    bit done;

    addsub_multi_fmt #(.WIDTH(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (op_a),
        .op_b    (op_b),
        .sub_en  (sub_en),
        .fmt_sel (fmt_sel),
        .result  (result),
        .overflow(overflow)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int twos_val(input int x);
        return (x >= HALF) ? x - (1 << W) : x;
    endfunction

    function automatic int ones_val(input int x);
        return (x >= HALF) ? -((~x) & MASK) : x;
    endfunction

    function automatic int abs_i(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // Compute expected result, overflow and the requirement tags
    task automatic expect_vec(input int f, input int s, input int a, input int b,
                              output int e_res, output int e_ovf,
                              output string t_res, output string t_ovf);
        int exact;
        int bb;
        int sum;
        int sa, sbe, ma, mb;
        if (f == 1) begin
            exact = ones_val(a) + (s != 0 ? -ones_val(b) : ones_val(b));
            e_ovf = (abs_i(exact) > HALF - 1) ? 1 : 0;
            bb    = (s != 0) ? ((~b) & MASK) : b;
            sum   = a + bb;
            if (sum > MASK) sum = (sum & MASK) + 1;
            e_res = sum;
            t_res = "R4";
            t_ovf = "R5";
        end else if (f == 2) begin
            sa  = (a >> (W - 1)) & 1;
            sbe = ((b >> (W - 1)) & 1) ^ s;
            ma  = a & (HALF - 1);
            mb  = b & (HALF - 1);
            exact = (sa != 0 ? -ma : ma) + (sbe != 0 ? -mb : mb);
            e_ovf = (abs_i(exact) > HALF - 1) ? 1 : 0;
            if (sa == sbe) begin
                e_res = (sa << (W - 1)) | ((ma + mb) & (HALF - 1));
                t_res = (s != 0) ? "R8" : "R6";
            end else begin
                e_res = ((exact < 0 ? 1 : 0) << (W - 1)) | abs_i(exact);
                t_res = (s != 0) ? "R8" : "R7";
            end
            t_ovf = (sa == sbe) ? "R6" : "R7";
        end else begin
            exact = twos_val(a) + (s != 0 ? -twos_val(b) : twos_val(b));
            e_ovf = (exact > HALF - 1 || exact < -HALF) ? 1 : 0;
            e_res = exact & MASK;
            t_res = (f == 3) ? "R9" : ((s != 0) ? "R2" : "R1");
            t_ovf = (f == 3) ? "R9" : "R3";
        end
    endtask

    initial begin
        int e_res, e_ovf;
        string t_res, t_ovf;
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        op_a     = W'(7);
        op_b     = W'(9);
        sub_en   = 1'b0;
        fmt_sel  = 2'd0;
        repeat (3) @(negedge clk);
        // R10: reset clears outputs
        check(result == '0, "R10", "reset result", int'(result), 0);
        check(overflow == 1'b0, "R10", "reset overflow", int'(overflow), 0);
        rst_n = 1'b1;
        op_a  = W'(3);
        op_b  = W'(4);
        #1;
        // R10: no change before the clock edge
        check(result == '0, "R10", "before edge", int'(result), 0);
        @(negedge clk);
        check(result == W'(7), "R10", "one edge later", int'(result), 7);

        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 2; s++) begin
                for (int a = 0; a <= MASK; a++) begin
                    for (int b = 0; b <= MASK; b++) begin
                        op_a    = W'(a);
                        op_b    = W'(b);
                        sub_en  = (s != 0);
                        fmt_sel = 2'(f);
                        @(negedge clk);
                        expect_vec(f, s, a, b, e_res, e_ovf, t_res, t_ovf);
                        check(int'(result) == e_res, t_res, "result", int'(result), e_res);
                        check(int'(overflow) == e_ovf, t_ovf, "overflow", int'(overflow), e_ovf);
                    end
                end
            end
        end

        // R10: synchronous reset clears a nonzero output
        op_a    = W'(5);
        op_b    = W'(5);
        fmt_sel = 2'd0;
        sub_en  = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(result == '0, "R10", "mid-run reset", int'(result), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule